// File: doc/BRIEF.md
# Supply Cascade Enable Sequencer

This block switches on a chain of downstream regulators one after another. Each regulator gets an active-low "power-up permitted" enable. An enable is given only after the supply feeding the previous link has been reported good by an external comparator, and then only after a programmable settling delay. The block does no analog work. It takes digital supply-good flags, a millisecond tick, a decoded delay field and a cascade-disable bit, and it produces registered enables that model open-drain pins (0 drives low, 1 releases).

The delay counter is a single resource that the stages share. It belongs to the reset generator whenever that generator is timing out a reset. A held manual reset also suspends the chain. In both cases the sequence freezes exactly where it stopped, including any partly counted delay, and it continues from that point once the hold is removed. After an enable has been asserted it stays asserted. Only a synchronous reset, or disabling the cascade, clears the chain.

Top module: `supply_cascade_seq`

## Requirements
- R1: When `rst` is high at a clock edge, `pwr_en_n` becomes all ones (released) and `stage` becomes 0.
- R2: Enables are asserted strictly in index order. `pwr_en_n[k]` never goes low while `pwr_en_n[k-1]` is high. No stage starts until `rail_good[0]` is high, so high flags on later rails alone do nothing.
- R3: `pwr_en_n[k]` uses delay code `dly_cfg[2k+1:2k]`: 00 = no delay, 01 = 25 ticks, 10 = 50 ticks, 11 = 100 ticks. The first clock edge that samples `rail_good[k]` high while stage k is current either asserts the enable directly (code 00) or starts the count. The enable then falls on the edge that samples the D-th later `ms_tick`.
- R4: A stage's count runs only while its flag is high. If the flag drops during the count, the count is discarded and starts again from zero when the flag returns.
- R5: The count advances only on clock edges where `ms_tick` is high.
- R6: While `casc_dis` is 1, one clock edge releases all enables and sets `stage` to 0, and the chain stays idle.
- R7: While `mr_hold_n` is 0, the count, `stage` and `pwr_en_n` are frozen. On release the partial count continues and does not restart.
- R8: While `rst_tmr_busy` is 1, the chain freezes exactly as in R7. The reset timeout has priority over the enable delays.
- R9: An asserted enable stays low even if any flag later drops, until `rst` or `casc_dis`.
- R10: `stage` always equals the number of asserted enables (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reinitialisation |
| rail_good | input | 3 | Supply-good flags; bit k gates enable k |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| casc_dis | input | 1 | 1 disables cascading |
| dly_cfg | input | 6 | Three 2-bit delay codes, stage k at bits [2k+1:2k] |
| mr_hold_n | input | 1 | Manual reset, low freezes the chain |
| rst_tmr_busy | input | 1 | Reset generator owns the shared timer |
| pwr_en_n | output | 3 | Active-low open-drain-style enables |
| stage | output | 2 | Number of enables asserted so far |

## Verification
The bench measures the exact edge on which each enable falls, for several delay-code mixes. An off-by-one in the count, or a field slice that is swapped, shows up as a wrong edge count. It pauses a running delay with each of the two hold inputs and expects the enable later by exactly the paused cycles. A design that restarts the count fires too late, and one that keeps counting fires too early. It drops a flag during a count and expects the full delay to run again from the moment the flag returns. It holds `ms_tick` low and expects no progress. It also drops flags after all enables are asserted and requires them to stay asserted, and it requires that disable, reset and far-rail flags neither start the chain nor leave stale enables.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef logic [1:0] dly_code_t;
  typedef enum logic {PH_WAIT = 1'b0, PH_COUNT = 1'b1} phase_e;
  localparam dly_code_t CODE_NONE  = 2'b00;
  localparam dly_code_t CODE_SHORT = 2'b01;
  localparam dly_code_t CODE_MID   = 2'b10;
endpackage

// File: rtl/cascade_delay_sel.sv
module cascade_delay_sel
  import seq_pkg::*;
#(
  parameter int N     = 3,
  parameter int SHORT = 25,
  parameter int MID   = 50,
  parameter int LONG  = 100,
  parameter int CW    = 7,
  parameter int SW    = 2
) (
  input  logic [2*N-1:0] field,
  input  logic [SW-1:0]  sel,
  output logic [CW-1:0]  target
);
  logic [CW-1:0] per_stage [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_dec
      dly_code_t code;
      assign code = field[2*g+1:2*g];
      assign per_stage[g] = (code == CODE_NONE)  ? '0 :
                            (code == CODE_SHORT) ? CW'(SHORT) :
                            (code == CODE_MID)   ? CW'(MID) : CW'(LONG);
    end
  endgenerate

  always_comb begin
    target = '0;
    for (int i = 0; i < N; i++)
      if (sel == SW'(i)) target = per_stage[i];
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  assign nxt  = {1'b0, cnt_q} + 1'b1;
  assign done = run && tick && (nxt == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  // R5: a count advances by exactly one per sampled tick, otherwise holds
  assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_count_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(run && tick)) |=> $stable(cnt_q));
  // R3: zero-delay codes never reach the counter
  assert_nonzero_limit_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (limit != '0));
endmodule

// File: rtl/supply_cascade_seq.sv
module supply_cascade_seq
  import seq_pkg::*;
#(
  parameter int N_STAGE  = 3,
  parameter int DLY_S    = 25,
  parameter int DLY_M    = 50,
  parameter int DLY_L    = 100
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_STAGE-1:0]           rail_good,
  input  logic                         ms_tick,
  input  logic                         casc_dis,
  input  logic [2*N_STAGE-1:0]         dly_cfg,
  input  logic                         mr_hold_n,
  input  logic                         rst_tmr_busy,
  output logic [N_STAGE-1:0]           pwr_en_n,
  output logic [$clog2(N_STAGE+1)-1:0] stage
);
  localparam int CW = $clog2(DLY_L + 1);
  localparam int SW = $clog2(N_STAGE + 1);

  logic [N_STAGE-1:0] en_n_q;
  logic [SW-1:0]      stage_q;
  phase_e             phase_q;
  logic               active, go, cur_ok, in_chain, fire, t_done, t_clr, t_run;
  logic [CW-1:0]      target;

  assign active   = !casc_dis;
  assign go       = active && mr_hold_n && !rst_tmr_busy;
  assign in_chain = (stage_q < SW'(N_STAGE));

  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < N_STAGE; i++)
      if (stage_q == SW'(i)) cur_ok = rail_good[i];
  end

  cascade_delay_sel #(
    .N(N_STAGE), .SHORT(DLY_S), .MID(DLY_M), .LONG(DLY_L), .CW(CW), .SW(SW)
  ) u_sel (
    .field (dly_cfg),
    .sel   (stage_q),
    .target(target)
  );

  assign t_run = go && (phase_q == PH_COUNT) && cur_ok;
  assign fire  = go && in_chain && cur_ok &&
                 (((phase_q == PH_WAIT) && (target == '0)) ||
                  ((phase_q == PH_COUNT) && t_done));
  assign t_clr = !active || (phase_q == PH_WAIT) || fire ||
                 (go && (phase_q == PH_COUNT) && !cur_ok);

  cascade_timer #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (t_clr),
    .run  (t_run),
    .tick (ms_tick),
    .limit(target),
    .done (t_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      en_n_q  <= '1;
      stage_q <= '0;
      phase_q <= PH_WAIT;
    end else if (go) begin
      if (fire) begin
        for (int i = 0; i < N_STAGE; i++)
          if (stage_q == SW'(i)) en_n_q[i] <= 1'b0;
        stage_q <= stage_q + 1'b1;
        phase_q <= PH_WAIT;
      end else if ((phase_q == PH_WAIT) && in_chain && cur_ok) begin
        phase_q <= PH_COUNT;
      end else if ((phase_q == PH_COUNT) && !cur_ok) begin
        phase_q <= PH_WAIT;
      end
    end
  end

  assign pwr_en_n = en_n_q;
  assign stage    = stage_q;

  // R6: disabling clears the chain one edge later
  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
    casc_dis |=> ((en_n_q == '1) && (stage_q == '0)));
  // R7: manual reset hold freezes the visible state
  assert_mr_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (!casc_dis && !mr_hold_n) |=> ($stable(en_n_q) && $stable(stage_q)));
  // R8: reset timer ownership freezes the visible state
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!casc_dis && rst_tmr_busy) |=> ($stable(en_n_q) && $stable(stage_q)));
  // R10: stage number tracks asserted enables
  assert_stage_count_R10: assert property (@(posedge clk) disable iff (rst)
    (32'(stage_q) == $countones(~en_n_q)));

  generate
    for (genvar k = 0; k < N_STAGE; k++) begin : g_chk
      // R9: asserted enables stay asserted while cascading stays on
      assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!casc_dis && !en_n_q[k]) |=> !en_n_q[k]);
      // R4: a stage cannot complete on an edge where its flag is low
      assert_flag_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (en_n_q[k] && !rail_good[k]) |=> en_n_q[k]);
      if (k > 0) begin : g_ord
        // R2: strict index order
        assert_order_R2: assert property (@(posedge clk) disable iff (rst)
          !en_n_q[k] |-> !en_n_q[k-1]);
      end
    end
  endgenerate
endmodule

// File: tb/supply_cascade_seq_test.sv
`timescale 1ns/100ps
module supply_cascade_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rail_good = '0;
  logic       ms_tick = 1'b1;
  logic       casc_dis = 1'b0;
  logic [5:0] dly_cfg = 6'b101010;
  logic       mr_hold_n = 1'b1;
  logic       rst_tmr_busy = 1'b0;
  logic [2:0] pwr_en_n;
  logic [1:0] stage;

  int vecs = 0;
  int bad  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  supply_cascade_seq uut (
    .clk(clk), .rst(rst), .rail_good(rail_good), .ms_tick(ms_tick),
    .casc_dis(casc_dis), .dly_cfg(dly_cfg), .mr_hold_n(mr_hold_n),
    .rst_tmr_busy(rst_tmr_busy), .pwr_en_n(pwr_en_n), .stage(stage)
  );

  // {cfg[5:0], ticks stage0, ticks stage1, ticks stage2}
  localparam logic [26:0] VEC [6] = '{
    {6'b101010, 7'd50,  7'd50,  7'd50},
    {6'b000000, 7'd0,   7'd0,   7'd0},
    {6'b111111, 7'd100, 7'd100, 7'd100},
    {6'b100100, 7'd0,   7'd25,  7'd50},
    {6'b011011, 7'd100, 7'd50,  7'd25},
    {6'b000110, 7'd50,  7'd25,  7'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rail_good = '0; casc_dis = 1'b0; mr_hold_n = 1'b1;
    rst_tmr_busy = 1'b0; ms_tick = 1'b1;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic measure(input int k, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (pwr_en_n[k] == 1'b0) break;
    end
  endtask

  initial begin
    int n;
    edges(3);
    check(pwr_en_n == 3'b111, "R1 reset enables", pwr_en_n, 7);
    check(stage == 2'd0, "R1 reset stage", stage, 0);
    rst = 1'b0;

    // vector table: delay codes per stage (R3), order (R2), stage count (R10)
    for (int v = 0; v < 6; v++) begin
      do_reset();
      dly_cfg = VEC[v][26:21];
      for (int s = 0; s < 3; s++) begin
        int exp_t;
        exp_t = (s == 0) ? int'(VEC[v][20:14]) : (s == 1) ? int'(VEC[v][13:7]) : int'(VEC[v][6:0]);
        rail_good[s] = 1'b1;
        measure(s, n);
        check(n == exp_t + 1, "R3 enable edge count", n, exp_t + 1);
        if (s < 2) begin
          edges(3);
          check(pwr_en_n[s+1] == 1'b1, "R2 next waits for its flag", pwr_en_n[s+1], 1);
        end
      end
      check(stage == 2'd3, "R10 stage after full chain", stage, 3);
    end

    // R9: flags drop after completion
    rail_good = '0;
    edges(20);
    check(pwr_en_n == 3'b000, "R9 enables stay asserted", pwr_en_n, 0);
    check(stage == 2'd3, "R9 stage kept", stage, 3);

    // R6: disabling mid-run clears in one edge
    casc_dis = 1'b1;
    edges(1);
    check(pwr_en_n == 3'b111, "R6 disable releases", pwr_en_n, 7);
    check(stage == 2'd0, "R6 disable stage", stage, 0);
    rail_good = 3'b111;
    edges(300);
    check(pwr_en_n == 3'b111, "R6 disabled stays idle", pwr_en_n, 7);

    // R2: later flags alone do nothing
    do_reset();
    dly_cfg = 6'b000000;
    rail_good = 3'b110;
    edges(300);
    check(pwr_en_n == 3'b111, "R2 no start without rail 0", pwr_en_n, 7);

    // R7: manual reset freezes a running delay (50)
    do_reset();
    dly_cfg = 6'b101010;
    rail_good[0] = 1'b1;
    edges(10);
    mr_hold_n = 1'b0;
    edges(40);
    check(pwr_en_n[0] == 1'b1 && stage == 2'd0, "R7 frozen during hold", pwr_en_n[0], 1);
    mr_hold_n = 1'b1;
    edges(40);
    check(pwr_en_n[0] == 1'b1, "R7 not before resumed count", pwr_en_n[0], 1);
    edges(1);
    check(pwr_en_n[0] == 1'b0, "R7 fires at frozen+remaining", pwr_en_n[0], 0);

    // R8: reset timer ownership freezes the delay
    do_reset();
    rail_good[0] = 1'b1;
    edges(10);
    rst_tmr_busy = 1'b1;
    edges(20);
    check(pwr_en_n[0] == 1'b1, "R8 frozen while timer busy", pwr_en_n[0], 1);
    rst_tmr_busy = 1'b0;
    edges(40);
    check(pwr_en_n[0] == 1'b1, "R8 not early", pwr_en_n[0], 1);
    edges(1);
    check(pwr_en_n[0] == 1'b0, "R8 fires after pause", pwr_en_n[0], 0);

    // R4: flag drop during a 25-tick count restarts it
    do_reset();
    dly_cfg = 6'b000001;
    rail_good[0] = 1'b1;
    edges(10);
    rail_good[0] = 1'b0;
    edges(3);
    check(pwr_en_n[0] == 1'b1, "R4 no fire while flag low", pwr_en_n[0], 1);
    rail_good[0] = 1'b1;
    edges(25);
    check(pwr_en_n[0] == 1'b1, "R4 count restarted", pwr_en_n[0], 1);
    edges(1);
    check(pwr_en_n[0] == 1'b0, "R4 fires after full delay", pwr_en_n[0], 0);

    // R5: no ticks, no progress
    do_reset();
    dly_cfg = 6'b000001;
    ms_tick = 1'b0;
    rail_good[0] = 1'b1;
    edges(100);
    check(pwr_en_n[0] == 1'b1, "R5 idle without ticks", pwr_en_n[0], 1);
    ms_tick = 1'b1;
    edges(24);
    check(pwr_en_n[0] == 1'b1, "R5 one tick short", pwr_en_n[0], 1);
    edges(1);
    check(pwr_en_n[0] == 1'b0, "R5 fires on 25th tick", pwr_en_n[0], 0);

    // R1: reset mid-chain reinitialises
    @(negedge clk);
    rst = 1'b1;
    edges(1);
    check(pwr_en_n == 3'b111 && stage == 2'd0, "R1 reset mid-chain", pwr_en_n, 7);
    rst = 1'b0;

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecs++;
      bad++;
      $display("FAIL watchdog (R1-R10 run): actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule